// File: doc/BRIEF.md
# Dual-Processor Mailbox Flag Controller

This block lets two processors signal each other through per-channel "occupied" flags. Each processor owns one flag per channel and raises it to tell the peer that a message is waiting. Only the peer can lower it, and lowering it acknowledges the message. Each processor has two level interrupts:

- a receive interrupt, raised while the peer holds an unmasked flag;
- a transmit interrupt, raised while one of its own unmasked channels is free.

Both interrupts read the same flag bits, seen from opposite sides.

Each processor has its own synchronous register port, and either port can reach the whole map. The map has two mirrored banks:

- bank 0 (processor 0) at byte address 0x000;
- bank 1 (processor 1) at 0x010.

Each bank has four word registers: control (+0x0), mask (+0x4), set/clear command (+0x8) and status (+0xC). The meaning of a bank access depends on the bank addressed, not on the port used. There are also two shared read-only identification words.

Top module: `mbx_flag_ctrl`

## Requirements
- R1: After reset, every flag is 0, both control registers read 0, both mask registers read all channel bits set (0x003F003F with 6 channels), and all four interrupts are low.
- R2: Writing a 1 to bit 16+n of bank p's command register sets processor p's flag n. The flag is visible at bit n of bank p's status register. The command register always reads 0.
- R3: Writing a 1 to bit n of bank p's command register clears the peer's flag n (processor 1-p). It never changes processor p's own flags. Flags without a set or clear keep their value.
- R4: irq_rx[p] is high when rx-enable (control bit 0 of bank p) is 1 and some peer flag n is 1 while receive mask bit n of bank p is 0.
- R5: irq_tx[p] is high when tx-enable (control bit 16 of bank p) is 1 and some own flag n is 0 while transmit mask bit 16+n of bank p is 0.
- R6: Both interrupts are levels gated by their enable bits. They fall in the cycle after the condition or the enable goes away.
- R7: When a set and a clear hit the same flag in the same cycle, the flag ends at 0.
- R8: Status and mask bits at channel positions at or above the channel count read 0, and writes to them are ignored.
- R9: Only control bits 0 and 16 are stored. All other control bits read 0.
- R10: Address 0x3F0 reads the channel count in bits 7:0. Address 0x3F4 reads the major revision in bits 7:4 and the minor revision in bits 3:0 (0x12 by default). Writes to both are ignored.
- R11: Unmapped or misaligned addresses read 0, and writes to them change nothing.
- R12: Read data appears on the port's rdata one cycle after a read request and is 0 in every cycle that follows no read.
- R13: If both ports write the same control or mask register in one cycle, port 0's data is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 2 | Per-port access request |
| bus_wr | input | 2 | Per-port write (1) or read (0) |
| bus_addr | input | 2 x ADDR_W | Per-port byte address |
| bus_wdata | input | 2 x 32 | Per-port write data |
| bus_rdata | output | 2 x 32 | Per-port read data, one cycle after the request |
| irq_rx | output | 2 | Receive-occupied interrupt per processor |
| irq_tx | output | 2 | Transmit-free interrupt per processor |

## Verification
A flag stored in the wrong state shows up in two places. It is seen at the status read one cycle after the request. It is also seen in the cycle after the bad update, as a wrong level on the receive interrupt of one processor and the transmit interrupt of the other. The interrupt outputs are therefore checked right after each command write, in both directions. Clear-over-set conflicts and two-port collisions are driven in the same cycle, so that a wrong resolution leaves a visible flag or mask value. Lost or stray mask and enable bits show up as interrupts that stay low or rise when they should not.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int NPROC = 2;

  typedef enum logic [2:0] {
    RG_NONE, RG_CTRL, RG_MASK, RG_CMD, RG_STAT, RG_CFG, RG_VER
  } reg_e;

  typedef struct packed {
    reg_e rg;
    logic bank;
  } hit_t;

  // Word index within a bank: 0 control, 1 mask, 2 command, 3 status.
  function automatic hit_t decode(input logic [15:0] a);
    hit_t h;
    h.rg   = RG_NONE;
    h.bank = a[4];
    if (a[1:0] == 2'b00) begin
      if (a[15:5] == '0) begin
        case (a[3:2])
          2'd0: h.rg = RG_CTRL;
          2'd1: h.rg = RG_MASK;
          2'd2: h.rg = RG_CMD;
          default: h.rg = RG_STAT;
        endcase
      end else if (a == 16'h03F0) begin
        h.rg = RG_CFG;
      end else if (a == 16'h03F4) begin
        h.rg = RG_VER;
      end
    end
    return h;
  endfunction
endpackage

// File: rtl/mbx_bank_cfg.sv
module mbx_bank_cfg #(
  parameter int NCH   = 6,
  parameter int NPORT = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [NPORT-1:0]            wr_ctrl,
  input  logic [NPORT-1:0]            wr_mask,
  input  logic [NPORT-1:0][31:0]      wdata,
  output logic                        rx_en,
  output logic                        tx_en,
  output logic [NCH-1:0]              rx_msk,
  output logic [NCH-1:0]              tx_msk
);
  logic        ctrl_we, mask_we;
  logic [31:0] ctrl_wd, mask_wd;

  // Lowest port index is applied last, so port 0 wins a collision.
  always_comb begin
    ctrl_we = 1'b0;
    mask_we = 1'b0;
    ctrl_wd = '0;
    mask_wd = '0;
    for (int i = NPORT - 1; i >= 0; i--) begin
      if (wr_ctrl[i]) begin
        ctrl_we = 1'b1;
        ctrl_wd = wdata[i];
      end
      if (wr_mask[i]) begin
        mask_we = 1'b1;
        mask_wd = wdata[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_en  <= 1'b0;
      tx_en  <= 1'b0;
      rx_msk <= '1;
      tx_msk <= '1;
    end else begin
      if (ctrl_we) begin
        rx_en <= ctrl_wd[0];
        tx_en <= ctrl_wd[16];
      end
      if (mask_we) begin
        rx_msk <= mask_wd[NCH-1:0];
        tx_msk <= mask_wd[16 +: NCH];
      end
    end
  end
endmodule

// File: rtl/mbx_flag_core.sv
module mbx_flag_core #(
  parameter int NCH   = 6,
  parameter int NPORT = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NPORT-1:0]       cmd_wr,
  input  logic [NPORT-1:0]       cmd_bank,
  input  logic [NPORT-1:0][31:0] wdata,
  output logic [1:0][NCH-1:0]    flag_q,
  output logic [1:0][NCH-1:0]    set_v,
  output logic [1:0][NCH-1:0]    clr_v
);
  // Upper half of a command sets the addressed bank's own flags,
  // lower half clears the other bank's flags.
  always_comb begin
    set_v = '0;
    clr_v = '0;
    for (int i = 0; i < NPORT; i++) begin
      if (cmd_wr[i]) begin
        set_v[cmd_bank[i]]  = set_v[cmd_bank[i]]  | wdata[i][16 +: NCH];
        clr_v[~cmd_bank[i]] = clr_v[~cmd_bank[i]] | wdata[i][NCH-1:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
    end else begin
      for (int p = 0; p < 2; p++) begin
        flag_q[p] <= (flag_q[p] | set_v[p]) & ~clr_v[p];
      end
    end
  end
endmodule

// File: rtl/mbx_irq_gen.sv
module mbx_irq_gen #(
  parameter int NCH = 6
) (
  input  logic           rx_en,
  input  logic           tx_en,
  input  logic [NCH-1:0] rx_msk,
  input  logic [NCH-1:0] tx_msk,
  input  logic [NCH-1:0] own_flag,
  input  logic [NCH-1:0] peer_flag,
  output logic           irq_rx,
  output logic           irq_tx
);
  assign irq_rx = rx_en & |(peer_flag & ~rx_msk);
  assign irq_tx = tx_en & |(~own_flag & ~tx_msk);
endmodule

// File: rtl/mbx_rd_port.sv
module mbx_rd_port #(
  parameter int NCH     = 6,
  parameter int VER_MAJ = 1,
  parameter int VER_MIN = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd,
  input  mbx_pkg::hit_t       hit,
  input  logic [1:0]          rx_en,
  input  logic [1:0]          tx_en,
  input  logic [1:0][NCH-1:0] rx_msk,
  input  logic [1:0][NCH-1:0] tx_msk,
  input  logic [1:0][NCH-1:0] flag_q,
  output logic [31:0]         rdata
);
  logic [31:0] val;

  always_comb begin
    val = '0;
    case (hit.rg)
      mbx_pkg::RG_CTRL: begin
        val[0]  = rx_en[hit.bank];
        val[16] = tx_en[hit.bank];
      end
      mbx_pkg::RG_MASK: begin
        val[NCH-1:0]  = rx_msk[hit.bank];
        val[16 +: NCH] = tx_msk[hit.bank];
      end
      mbx_pkg::RG_STAT: val[NCH-1:0] = flag_q[hit.bank];
      mbx_pkg::RG_CFG:  val[7:0] = 8'(NCH);
      mbx_pkg::RG_VER:  val[7:0] = {4'(VER_MAJ), 4'(VER_MIN)};
      default:          val = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rdata <= '0;
    else        rdata <= rd ? val : 32'h0;
  end
endmodule

// File: rtl/mbx_flag_ctrl.sv
module mbx_flag_ctrl #(
  parameter int NCH     = 6,
  parameter int ADDR_W  = 10,
  parameter int VER_MAJ = 1,
  parameter int VER_MIN = 2
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [mbx_pkg::NPROC-1:0]           bus_sel,
  input  logic [mbx_pkg::NPROC-1:0]           bus_wr,
  input  logic [mbx_pkg::NPROC-1:0][ADDR_W-1:0] bus_addr,
  input  logic [mbx_pkg::NPROC-1:0][31:0]     bus_wdata,
  output logic [mbx_pkg::NPROC-1:0][31:0]     bus_rdata,
  output logic [mbx_pkg::NPROC-1:0]           irq_rx,
  output logic [mbx_pkg::NPROC-1:0]           irq_tx
);
  localparam int NP = mbx_pkg::NPROC;

  mbx_pkg::hit_t          hit [NP];
  logic [NP-1:0]          cmd_wr, cmd_bank, rd_req;
  logic [NP-1:0][NP-1:0]  wr_ctrl, wr_mask;   // [bank][port]
  logic [1:0]             rx_en, tx_en;
  logic [1:0][NCH-1:0]    rx_msk, tx_msk;
  logic [1:0][NCH-1:0]    flag_q, set_v, clr_v;

  for (genvar i = 0; i < NP; i++) begin : g_port
    assign hit[i]      = mbx_pkg::decode(16'(bus_addr[i]));
    assign cmd_wr[i]   = bus_sel[i] & bus_wr[i] & (hit[i].rg == mbx_pkg::RG_CMD);
    assign cmd_bank[i] = hit[i].bank;
    assign rd_req[i]   = bus_sel[i] & ~bus_wr[i];
    for (genvar b = 0; b < NP; b++) begin : g_bank
      assign wr_ctrl[b][i] = bus_sel[i] & bus_wr[i] & (hit[i].bank == 1'(b))
                             & (hit[i].rg == mbx_pkg::RG_CTRL);
      assign wr_mask[b][i] = bus_sel[i] & bus_wr[i] & (hit[i].bank == 1'(b))
                             & (hit[i].rg == mbx_pkg::RG_MASK);
    end
    mbx_rd_port #(.NCH(NCH), .VER_MAJ(VER_MAJ), .VER_MIN(VER_MIN)) u_rd (
      .clk(clk), .rst_n(rst_n), .rd(rd_req[i]), .hit(hit[i]),
      .rx_en(rx_en), .tx_en(tx_en), .rx_msk(rx_msk), .tx_msk(tx_msk),
      .flag_q(flag_q), .rdata(bus_rdata[i])
    );
  end

  for (genvar b = 0; b < NP; b++) begin : g_proc
    mbx_bank_cfg #(.NCH(NCH), .NPORT(NP)) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl[b]), .wr_mask(wr_mask[b]),
      .wdata(bus_wdata), .rx_en(rx_en[b]), .tx_en(tx_en[b]),
      .rx_msk(rx_msk[b]), .tx_msk(tx_msk[b])
    );
    mbx_irq_gen #(.NCH(NCH)) u_irq (
      .rx_en(rx_en[b]), .tx_en(tx_en[b]), .rx_msk(rx_msk[b]), .tx_msk(tx_msk[b]),
      .own_flag(flag_q[b]), .peer_flag(flag_q[1-b]),
      .irq_rx(irq_rx[b]), .irq_tx(irq_tx[b])
    );
  end

  mbx_flag_core #(.NCH(NCH), .NPORT(NP)) u_core (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_bank(cmd_bank),
    .wdata(bus_wdata), .flag_q(flag_q), .set_v(set_v), .clr_v(clr_v)
  );
endmodule

// File: rtl/mbx_flag_ctrl_chk.sv
module mbx_flag_ctrl_chk #(
  parameter int NCH    = 6,
  parameter int ADDR_W = 10
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic [1:0]             bus_sel,
  input logic [1:0]             bus_wr,
  input logic [1:0][ADDR_W-1:0] bus_addr,
  input logic [1:0][31:0]       bus_rdata,
  input logic [1:0]             irq_rx,
  input logic [1:0]             irq_tx,
  input logic [1:0][NCH-1:0]    flag_q,
  input logic [1:0][NCH-1:0]    set_v,
  input logic [1:0][NCH-1:0]    clr_v
);
  for (genvar p = 0; p < 2; p++) begin : g_p
    p_set_sticks_r2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((flag_q[p] & $past(set_v[p] & ~clr_v[p])) == $past(set_v[p] & ~clr_v[p])));

    p_flag_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (((flag_q[p] ^ $past(flag_q[p])) & ~$past(set_v[p] | clr_v[p])) == '0));

    p_clear_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
      ((set_v[p] & clr_v[p]) != '0) |=> ((flag_q[p] & $past(set_v[p] & clr_v[p])) == '0));

    p_rx_needs_peer_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[1-p] == '0) |-> !irq_rx[p]);

    p_tx_needs_free_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (&flag_q[p]) |-> !irq_tx[p]);

    p_idle_read_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_sel[p] && !bus_wr[p]) |=> (bus_rdata[p] == 32'h0));

    p_cfg_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel[p] && !bus_wr[p] && bus_addr[p] == ADDR_W'(16'h03F0))
      |=> (bus_rdata[p] == 32'(NCH)));
  end
endmodule

bind mbx_flag_ctrl mbx_flag_ctrl_chk #(.NCH(NCH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .irq_rx(irq_rx), .irq_tx(irq_tx),
  .flag_q(flag_q), .set_v(set_v), .clr_v(clr_v)
);

// File: tb/mbx_flag_ctrl_tb.sv
module mbx_flag_ctrl_tb;
  localparam int NCH = 6;
  localparam int AW  = 10;

  logic               clk = 1'b0;
  logic               rst_n = 1'b0;
  logic [1:0]         bus_sel = '0;
  logic [1:0]         bus_wr = '0;
  logic [1:0][AW-1:0] bus_addr = '0;
  logic [1:0][31:0]   bus_wdata = '0;
  logic [1:0][31:0]   bus_rdata;
  logic [1:0]         irq_rx, irq_tx;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  mbx_flag_ctrl #(.NCH(NCH), .ADDR_W(AW)) u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_rx(irq_rx), .irq_tx(irq_tx)
  );

  localparam logic [AW-1:0] C0 = 10'h000, M0 = 10'h004, K0 = 10'h008, S0 = 10'h00C;
  localparam logic [AW-1:0] C1 = 10'h010, M1 = 10'h014, K1 = 10'h018, S1 = 10'h01C;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input int p, input logic [AW-1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel[p] = 1'b1; bus_wr[p] = 1'b1; bus_addr[p] = a; bus_wdata[p] = d;
    @(negedge clk);
    bus_sel[p] = 1'b0; bus_wr[p] = 1'b0;
  endtask

  task automatic wr2(input logic [AW-1:0] a0, input logic [31:0] d0,
                     input logic [AW-1:0] a1, input logic [31:0] d1);
    @(negedge clk);
    bus_sel = 2'b11; bus_wr = 2'b11;
    bus_addr[0] = a0; bus_wdata[0] = d0;
    bus_addr[1] = a1; bus_wdata[1] = d1;
    @(negedge clk);
    bus_sel = 2'b00; bus_wr = 2'b00;
  endtask

  task automatic rd_chk(input int p, input logic [AW-1:0] a, input logic [31:0] exp,
                        input string req);
    @(negedge clk);
    bus_sel[p] = 1'b1; bus_wr[p] = 1'b0; bus_addr[p] = a;
    @(negedge clk);
    bus_sel[p] = 1'b0;
    check(req, bus_rdata[p], exp);
  endtask

  task automatic t_reset;
    check("R1 irq", {28'h0, irq_rx, irq_tx}, 32'h0);
    rd_chk(0, C0, 32'h0, "R1 ctrl0");
    rd_chk(1, C1, 32'h0, "R1 ctrl1");
    rd_chk(0, M0, 32'h003F003F, "R1 mask0");
    rd_chk(1, M1, 32'h003F003F, "R1 mask1");
    rd_chk(0, S0, 32'h0, "R1 stat0");
    rd_chk(1, S1, 32'h0, "R1 stat1");
  endtask

  task automatic t_id;
    rd_chk(0, 10'h3F0, 32'd6, "R10 cfg");
    rd_chk(1, 10'h3F4, 32'h12, "R10 ver");
    wr(0, 10'h3F0, 32'hFFFF_FFFF);
    rd_chk(0, 10'h3F0, 32'd6, "R10 cfg write ignored");
  endtask

  task automatic t_ctrl_mask;
    wr(0, C0, 32'hFFFF_FFFF);
    rd_chk(0, C0, 32'h0001_0001, "R9 ctrl bits");
    wr(0, C0, 32'h0);
    wr(1, M1, 32'h0);
    rd_chk(1, M1, 32'h0, "R8 mask cleared");
    wr(1, M1, 32'hFFFF_FFFF);
    rd_chk(1, M1, 32'h003F003F, "R8 mask upper bits");
  endtask

  task automatic t_setclr;
    wr(0, K0, 32'h0004_0000);
    rd_chk(0, S0, 32'h4, "R2 set own flag");
    rd_chk(0, K0, 32'h0, "R2 cmd reads zero");
    wr(0, K0, 32'h0000_0004);
    rd_chk(0, S0, 32'h4, "R3 own clear bits do not touch own flag");
    wr(1, K1, 32'h0000_0004);
    rd_chk(1, S0, 32'h0, "R3 peer clears flag");
    wr(1, K1, 32'hFFFF_0000);
    rd_chk(1, S1, 32'h3F, "R8 status above count");
    wr(0, K0, 32'h0000_FFFF);
    rd_chk(0, S1, 32'h0, "R3 clear all of bank1");
  endtask

  task automatic t_rx;
    wr(1, C1, 32'h1);
    wr(1, M1, 32'h003F0037);
    wr(0, K0, 32'h0004_0000);
    check("R4 masked channel no irq", {31'h0, irq_rx[1]}, 32'h0);
    wr(0, K0, 32'h0008_0000);
    check("R4 rx irq up", {31'h0, irq_rx[1]}, 32'h1);
    check("R4 other rx low", {31'h0, irq_rx[0]}, 32'h0);
    wr(1, K1, 32'h0000_0008);
    check("R6 rx irq drops", {31'h0, irq_rx[1]}, 32'h0);
    wr(1, K1, 32'h0000_0004);
    wr(1, C1, 32'h0);
    wr(1, M1, 32'h003F003F);
  endtask

  task automatic t_tx;
    wr(0, C0, 32'h0001_0000);
    check("R5 masked no tx", {31'h0, irq_tx[0]}, 32'h0);
    wr(0, M0, 32'h003E003F);
    check("R5 tx irq free channel", {31'h0, irq_tx[0]}, 32'h1);
    wr(0, K0, 32'h0001_0000);
    check("R5 tx low while occupied", {31'h0, irq_tx[0]}, 32'h0);
    wr(1, K1, 32'h0000_0001);
    check("R5 tx back after ack", {31'h0, irq_tx[0]}, 32'h1);
    wr(0, C0, 32'h0);
    check("R6 enable gates tx", {31'h0, irq_tx[0]}, 32'h0);
    wr(0, M0, 32'h003F003F);
  endtask

  task automatic t_conflict;
    wr2(K0, 32'h0010_0000, K1, 32'h0000_0010);
    rd_chk(0, S0, 32'h0, "R7 clear wins on fresh set");
    wr(0, K0, 32'h0020_0000);
    wr2(K0, 32'h0020_0000, K1, 32'h0000_0020);
    rd_chk(0, S0, 32'h0, "R7 clear wins on held flag");
  endtask

  task automatic t_prio;
    wr2(M0, 32'h0001_0002, M0, 32'h0004_0008);
    rd_chk(1, M0, 32'h0001_0002, "R13 port0 wins mask");
    wr2(C1, 32'h0000_0001, C1, 32'h0001_0000);
    rd_chk(0, C1, 32'h0000_0001, "R13 port0 wins ctrl");
    wr(0, M0, 32'h003F003F);
    wr(0, C1, 32'h0);
  endtask

  task automatic t_unmapped;
    wr(0, 10'h020, 32'hFFFF_FFFF);
    wr(1, 10'h006, 32'hFFFF_FFFF);
    wr(0, 10'h00A, 32'hFFFF_FFFF);
    wr(1, 10'h3F8, 32'hFFFF_FFFF);
    rd_chk(0, 10'h020, 32'h0, "R11 unmapped read");
    rd_chk(1, 10'h3F8, 32'h0, "R11 high unmapped read");
    rd_chk(0, 10'h005, 32'h0, "R11 misaligned read");
    rd_chk(1, M0, 32'h003F003F, "R11 mask untouched");
    rd_chk(0, S0, 32'h0, "R11 flags untouched");
    rd_chk(1, S1, 32'h0, "R11 flags1 untouched");
  endtask

  task automatic t_rdlat;
    rd_chk(1, M1, 32'h003F003F, "R12 data one cycle later");
    @(negedge clk);
    check("R12 idle rdata zero", bus_rdata[1], 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=hang expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset;
    t_id;
    t_ctrl_mask;
    t_setclr;
    t_rx;
    t_tx;
    t_conflict;
    t_prio;
    t_unmapped;
    t_rdlat;
    repeat (2) @(negedge clk);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule